// File: doc/BRIEF.md
# AUX Channel Transaction Sequencer

This block runs a single DisplayPort AUX request of up to sixteen payload bytes from start to finish. A host pulses `start` with a command type, a 20-bit target address, a byte count and, for writes, the payload. The sequencer then does four things in turn. It waits for the channel to go quiet and takes ownership of it. It confirms that a sink is attached. It sends the request and retries it as needed. It reports a two-bit result with a single `done` pulse. The serial electrical layer is not part of this block. It sits behind a simple PHY port: a level request, a done strobe, a reply-error field, and the packed request and reply data words.

Every wait is measured in microseconds. A free-running prescaler turns the core clock into a one-microsecond tick. Each phase has its own tick limit. A failed attempt starts with a channel reset pulse and then waits a fixed back-off time before the request is sent again. The block gives up after a set number of attempts. Ownership is always released when the transaction ends.

Top module: `aux_txn_seq`

## Requirements
- R1: While `xfer_req` is high, `ctl_cmd` equals the command type, `ctl_len` equals byte count minus one, and `ctl_addr` equals the address, all captured at start. The payload on `wr_words` puts byte i at bits [8i+7:8i], so 32-bit word k holds bytes 4k to 4k+3 with byte 4k as its low byte. Bytes at or beyond the count read as zero. The whole vector is zero for a read, which is a command type with bit 0 set.
- R2: After start, the block waits for `chan_busy` to be low before it raises `own_req`. If `chan_busy` stays high for IDLE_TMO_US ticks, the transaction ends with result 1 (busy) and `own_req` is never raised.
- R3: If `grant` is not seen within GRANT_TMO_US ticks of raising `own_req`, the transaction ends with result 1 (busy).
- R4: Once `grant` arrives, a low `sink_present` ends the transaction with result 2 (no device). No `xfer_req` is raised in that case.
- R5: Every attempt begins with a one-cycle `chan_rst` pulse, during which `xfer_req` is low. On the first attempt, `xfer_req` rises on the next cycle. On every later attempt, `xfer_req` rises only after BACKOFF_US ticks.
- R6: An attempt succeeds when `xfer_done` arrives with `reply_err` equal to zero, and the result is 0 (ok). A nonzero `reply_err` starts another attempt. After MAX_TRIES failed attempts the result is 3 (I/O error).
- R7: If `xfer_done` does not arrive within DONE_TMO_US ticks of raising `xfer_req`, the result is 3 (I/O error) and no further attempt is made.
- R8: After a successful read, byte i of `rdata` equals byte i of `rd_words` for i below the count, and every other byte is zero. A write, or a read that fails, leaves `rdata` unchanged.
- R9: `own_req` is high whenever `xfer_req` is high, and it is low in the cycle that `done` pulses, whichever way the transaction ended.
- R10: A `start` pulse while `busy` is high is ignored. No second transaction and no extra `done` pulse follow from it.
- R11: `done` is a one-cycle pulse with `result` valid in that cycle. `busy` is high from the cycle after start until `done`.
- R12: After reset, `busy`, `done`, `own_req`, `chan_rst` and `xfer_req` are low and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction (ignored while busy) |
| cmd_type | input | 4 | Command type; bit 0 set means read |
| addr | input | 20 | Target address |
| byte_count | input | CNT_W (5) | Payload bytes, 1 to NBYTES |
| wdata | input | 8*NBYTES (128) | Write payload, byte i at [8i+7:8i] |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction strobe |
| result | output | 2 | 0 ok, 1 busy, 2 no device, 3 I/O error |
| rdata | output | 8*NBYTES (128) | Read payload from the last successful read |
| own_req | output | 1 | Channel ownership request |
| grant | input | 1 | Ownership granted |
| chan_busy | input | 1 | Channel busy or request still pending |
| sink_present | input | 1 | Sink detected on the channel |
| chan_rst | output | 1 | One-cycle channel reset at attempt start |
| xfer_req | output | 1 | Request level, held until xfer_done or timeout |
| xfer_done | input | 1 | Request completed strobe |
| reply_err | input | ERR_W (8) | Reply error bits, all zero on success |
| ctl_cmd | output | 4 | Command field to the PHY |
| ctl_len | output | LEN_W (4) | Length field, count minus one |
| ctl_addr | output | 20 | Address to the PHY |
| wr_words | output | 8*NBYTES (128) | Packed write words to the PHY |
| rd_words | input | 8*NBYTES (128) | Packed reply words from the PHY |

## Verification
The bench targets five corner cases. The first is a transaction whose attempts fail several times before one succeeds. Here the bench counts reset pulses and requests, and it measures the gap between each reset and the request that follows. A design that skipped the back-off, or applied it to the first attempt as well, shows the wrong gap. The second is a reply that never completes. A design that retried after that timeout would show more than one request. The third is a sink that is absent. A design that did not gate on sink presence would raise a request anyway. The fourth and fifth are a busy channel and a grant that never arrives. Both must end with result 1 and ownership released. Beyond these, random transactions check byte masking past the count, the length field, and the rule that a failed read leaves the previous read data in place.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;

   typedef enum logic [1:0] {
      RES_OK    = 2'd0,
      RES_BUSY  = 2'd1,
      RES_NODEV = 2'd2,
      RES_IOERR = 2'd3
   } aux_res_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_WAIT_IDLE,
      S_WAIT_GRANT,
      S_SINK,
      S_RESET,
      S_BACKOFF,
      S_ISSUE
   } aux_state_e;

endpackage

// File: rtl/aux_us_tick.sv
module aux_us_tick #(
   parameter int CLKS_PER_US = 100
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int PW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;

   generate
      if (CLKS_PER_US <= 1) begin : g_every_clk
         assign tick = 1'b1;
      end else begin : g_divide
         logic [PW-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             pre_q <= '0;
            else if (pre_q == PW'(CLKS_PER_US - 1)) pre_q <= '0;
            else                                    pre_q <= pre_q + 1'b1;
         end
         assign tick = (pre_q == PW'(CLKS_PER_US - 1));
      end
   endgenerate
endmodule

// File: rtl/aux_phase_timer.sv
module aux_phase_timer #(
   parameter int TW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          tick,
   input  logic [TW-1:0] limit,
   output logic          expired
);
   logic [TW-1:0] cnt_q;

   assign expired = (cnt_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (restart)        cnt_q <= '0;
      else if (tick && !expired) cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/aux_byte_mask.sv
module aux_byte_mask #(
   parameter int NBYTES    = 16,
   parameter int CNT_W     = 5,
   parameter bit ZERO_FILL = 1'b1
) (
   input  logic [8*NBYTES-1:0] din,
   input  logic [CNT_W-1:0]    count,
   output logic [8*NBYTES-1:0] dout
);
   generate
      for (genvar b = 0; b < NBYTES; b++) begin : g_byte
         if (ZERO_FILL) begin : g_fill
            assign dout[8*b +: 8] = (count > CNT_W'(b)) ? din[8*b +: 8] : 8'h00;
         end else begin : g_pass
            assign dout[8*b +: 8] = din[8*b +: 8];
         end
      end
   endgenerate
endmodule

// File: rtl/aux_txn_seq.sv
module aux_txn_seq
   import aux_seq_pkg::*;
#(
   parameter int NBYTES       = 16,
   parameter int ADDR_W       = 20,
   parameter int CMD_W        = 4,
   parameter int ERR_W        = 8,
   parameter int CLKS_PER_US  = 100,
   parameter int IDLE_TMO_US  = 1000,
   parameter int GRANT_TMO_US = 1000,
   parameter int DONE_TMO_US  = 1000,
   parameter int BACKOFF_US   = 400,
   parameter int MAX_TRIES    = 32,
   parameter bit ZERO_FILL    = 1'b1,
   localparam int CNT_W = $clog2(NBYTES + 1),
   localparam int LEN_W = $clog2(NBYTES),
   localparam int DW    = 8 * NBYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CMD_W-1:0]  cmd_type,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  byte_count,
   input  logic [DW-1:0]     wdata,
   output logic              busy,
   output logic              done,
   output logic [1:0]        result,
   output logic [DW-1:0]     rdata,
   output logic              own_req,
   input  logic              grant,
   input  logic              chan_busy,
   input  logic              sink_present,
   output logic              chan_rst,
   output logic              xfer_req,
   input  logic              xfer_done,
   input  logic [ERR_W-1:0]  reply_err,
   output logic [CMD_W-1:0]  ctl_cmd,
   output logic [LEN_W-1:0]  ctl_len,
   output logic [ADDR_W-1:0] ctl_addr,
   output logic [DW-1:0]     wr_words,
   input  logic [DW-1:0]     rd_words
);
   localparam int TMR_MAX01 = (IDLE_TMO_US > GRANT_TMO_US) ? IDLE_TMO_US : GRANT_TMO_US;
   localparam int TMR_MAX23 = (DONE_TMO_US > BACKOFF_US) ? DONE_TMO_US : BACKOFF_US;
   localparam int TMR_MAX   = (TMR_MAX01 > TMR_MAX23) ? TMR_MAX01 : TMR_MAX23;
   localparam int TW        = $clog2(TMR_MAX + 1);
   localparam int ATT_W     = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;

   generate
      if (NBYTES % 4 != 0 || NBYTES < 4) begin : g_bad_nbytes
         $error("NBYTES must be a positive multiple of 4");
      end
      if (MAX_TRIES < 1) begin : g_bad_tries
         $error("MAX_TRIES must be at least 1");
      end
      if (CLKS_PER_US < 1) begin : g_bad_clk
         $error("CLKS_PER_US must be at least 1");
      end
   endgenerate

   aux_state_e        state_q, state_d;
   logic [ATT_W-1:0]  att_q;
   logic [CMD_W-1:0]  cmd_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [LEN_W-1:0]  len_q;
   logic [DW-1:0]     wr_q, rdata_q;
   logic              done_q;
   aux_res_e          res_q;

   logic              tick, tmr_exp, tmr_restart;
   logic [TW-1:0]     tmr_limit;
   logic              fin, att_inc, att_clr, cap_rd;
   aux_res_e          fin_code;
   logic [DW-1:0]     wr_masked, rd_masked;
   logic [CNT_W-1:0]  cnt_m1;
   logic              is_rd;

   assign is_rd  = cmd_q[0];
   assign cnt_m1 = byte_count - CNT_W'(1);

   aux_us_tick #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
      .clk (clk), .rst_n (rst_n), .tick (tick)
   );

   aux_phase_timer #(.TW(TW)) u_tmr (
      .clk (clk), .rst_n (rst_n), .restart (tmr_restart), .tick (tick),
      .limit (tmr_limit), .expired (tmr_exp)
   );

   aux_byte_mask #(.NBYTES(NBYTES), .CNT_W(CNT_W), .ZERO_FILL(ZERO_FILL)) u_wmask (
      .din (wdata), .count (byte_count), .dout (wr_masked)
   );

   aux_byte_mask #(.NBYTES(NBYTES), .CNT_W(CNT_W), .ZERO_FILL(ZERO_FILL)) u_rmask (
      .din (rd_words), .count (cnt_q), .dout (rd_masked)
   );

   always_comb begin
      case (state_q)
         S_WAIT_IDLE:  tmr_limit = TW'(IDLE_TMO_US);
         S_WAIT_GRANT: tmr_limit = TW'(GRANT_TMO_US);
         S_BACKOFF:    tmr_limit = TW'(BACKOFF_US);
         default:      tmr_limit = TW'(DONE_TMO_US);
      endcase
   end

   always_comb begin
      state_d  = state_q;
      fin      = 1'b0;
      fin_code = RES_OK;
      att_inc  = 1'b0;
      att_clr  = 1'b0;
      cap_rd   = 1'b0;
      case (state_q)
         S_IDLE: if (start) state_d = S_WAIT_IDLE;
         S_WAIT_IDLE: begin
            if (!chan_busy)   state_d = S_WAIT_GRANT;
            else if (tmr_exp) begin fin = 1'b1; fin_code = RES_BUSY; end
         end
         S_WAIT_GRANT: begin
            if (grant)        state_d = S_SINK;
            else if (tmr_exp) begin fin = 1'b1; fin_code = RES_BUSY; end
         end
         S_SINK: begin
            if (!sink_present) begin fin = 1'b1; fin_code = RES_NODEV; end
            else begin state_d = S_RESET; att_clr = 1'b1; end
         end
         S_RESET:   state_d = (att_q == '0) ? S_ISSUE : S_BACKOFF;
         S_BACKOFF: if (tmr_exp) state_d = S_ISSUE;
         S_ISSUE: begin
            if (xfer_done) begin
               if (reply_err == '0) begin
                  fin = 1'b1; fin_code = RES_OK; cap_rd = is_rd;
               end else if (att_q == ATT_W'(MAX_TRIES - 1)) begin
                  fin = 1'b1; fin_code = RES_IOERR;
               end else begin
                  att_inc = 1'b1; state_d = S_RESET;
               end
            end else if (tmr_exp) begin
               fin = 1'b1; fin_code = RES_IOERR;
            end
         end
         default: state_d = S_IDLE;
      endcase
      if (fin) state_d = S_IDLE;
   end

   assign tmr_restart = (state_d != state_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         att_q   <= '0;
         cmd_q   <= '0;
         addr_q  <= '0;
         cnt_q   <= '0;
         len_q   <= '0;
         wr_q    <= '0;
         rdata_q <= '0;
         done_q  <= 1'b0;
         res_q   <= RES_OK;
      end else begin
         state_q <= state_d;
         done_q  <= fin;
         if (fin) res_q <= fin_code;
         if (state_q == S_IDLE && start) begin
            cmd_q  <= cmd_type;
            addr_q <= addr;
            cnt_q  <= byte_count;
            len_q  <= cnt_m1[LEN_W-1:0];
            wr_q   <= cmd_type[0] ? '0 : wr_masked;
         end
         if (att_clr)      att_q <= '0;
         else if (att_inc) att_q <= att_q + 1'b1;
         if (cap_rd) rdata_q <= rd_masked;
      end
   end

   assign busy     = (state_q != S_IDLE);
   assign done     = done_q;
   assign result   = res_q;
   assign rdata    = rdata_q;
   assign own_req  = (state_q == S_WAIT_GRANT) || (state_q == S_SINK) ||
                     (state_q == S_RESET) || (state_q == S_BACKOFF) ||
                     (state_q == S_ISSUE);
   assign chan_rst = (state_q == S_RESET);
   assign xfer_req = (state_q == S_ISSUE);
   assign ctl_cmd  = cmd_q;
   assign ctl_len  = len_q;
   assign ctl_addr = addr_q;
   assign wr_words = wr_q;
endmodule

// File: rtl/aux_txn_seq_chk.sv
module aux_txn_seq_chk #(
   parameter int CMD_W  = 4,
   parameter int LEN_W  = 4,
   parameter int ADDR_W = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              own_req,
   input logic              xfer_req,
   input logic              chan_rst,
   input logic              done,
   input logic [CMD_W-1:0]  ctl_cmd,
   input logic [LEN_W-1:0]  ctl_len,
   input logic [ADDR_W-1:0] ctl_addr
);
   p_req_owned_r9: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |-> own_req);

   p_done_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!own_req && !xfer_req));

   p_rst_no_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      chan_rst |-> !xfer_req);

   p_rst_then_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xfer_req) |-> ($past(chan_rst) || $past(own_req)));

   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_ctl_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && $past(xfer_req)) |-> $stable({ctl_cmd, ctl_len, ctl_addr}));
endmodule

bind aux_txn_seq aux_txn_seq_chk #(.CMD_W(CMD_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_chk (
   .clk (clk), .rst_n (rst_n), .own_req (own_req), .xfer_req (xfer_req),
   .chan_rst (chan_rst), .done (done), .ctl_cmd (ctl_cmd), .ctl_len (ctl_len),
   .ctl_addr (ctl_addr)
);

// File: tb/aux_txn_seq_tb.sv
module aux_txn_seq_tb;
   localparam int NB   = 16;
   localparam int DW   = 8 * NB;
   localparam int C    = 2;
   localparam int TIDL = 1000;
   localparam int TGR  = 1000;
   localparam int TDN  = 1000;
   localparam int BOFF = 400;
   localparam int MAXT = 32;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 1'b0;
   logic [3:0] cmd_type = '0;
   logic [19:0] addr = '0;
   logic [4:0] byte_count = 5'd1;
   logic [DW-1:0] wdata = '0;
   logic busy, done, own_req, chan_rst, xfer_req;
   logic [1:0] result;
   logic [DW-1:0] rdata, wr_words;
   logic grant = 1'b0, chan_busy = 1'b0, sink_present = 1'b1, xfer_done = 1'b0;
   logic [7:0] reply_err = '0;
   logic [3:0] ctl_cmd;
   logic [3:0] ctl_len;
   logic [19:0] ctl_addr;
   logic [DW-1:0] rd_words = '0;

   aux_txn_seq #(.CLKS_PER_US(C)) u_dut (.*);

   always #5 clk = ~clk;

   int n_cmp = 0, n_bad = 0;
   int grant_en = 1, grant_dly = 3, done_dly = 5, hang = 0, fail_n = 0;
   int pcnt = 0, own_cnt = 0, dcnt = 0;

   // PHY model
   always @(posedge clk) begin
      xfer_done <= 1'b0;
      if (!busy) pcnt <= 0;
      own_cnt <= own_req ? own_cnt + 1 : 0;
      grant <= own_req && (grant_en != 0) && (own_cnt >= grant_dly);
      if (xfer_req && !xfer_done && hang == 0) begin
         if (dcnt >= done_dly) begin
            xfer_done <= 1'b1;
            reply_err <= (pcnt < fail_n) ? (8'h01 << (pcnt % 8)) : 8'h00;
            pcnt <= pcnt + 1;
            dcnt <= 0;
         end else dcnt <= dcnt + 1;
      end else dcnt <= 0;
   end

   // Monitor sampled away from the active edge
   int cyc = 0, n_rst = 0, n_att = 0, n_done = 0, t_rst = 0, first_gap = 0;
   int gap_min = 0, gap_max = 0, t_req = 0, t_done = 0;
   logic prev_req = 1'b0, own_at_done = 1'b0, own_seen = 1'b0;
   logic [1:0] res_seen = '0;
   logic [3:0] f_cmd, f_len;
   logic [19:0] f_addr;
   logic [DW-1:0] f_wr;
   always @(negedge clk) begin
      cyc++;
      if (own_req) own_seen = 1'b1;
      if (chan_rst) begin n_rst++; t_rst = cyc; end
      if (xfer_req && !prev_req) begin
         n_att++;
         t_req = cyc;
         if (n_att == 1) begin
            first_gap = cyc - t_rst;
            f_cmd = ctl_cmd; f_len = ctl_len; f_addr = ctl_addr; f_wr = wr_words;
         end else begin
            if (n_att == 2 || cyc - t_rst < gap_min) gap_min = cyc - t_rst;
            if (n_att == 2 || cyc - t_rst > gap_max) gap_max = cyc - t_rst;
         end
      end
      if (done) begin n_done++; res_seen = result; own_at_done = own_req; t_done = cyc; end
      prev_req = xfer_req;
   end

   task automatic step();
      @(posedge clk); #2;
   endtask

   task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] f_mask(input logic [DW-1:0] d, input int n);
      logic [DW-1:0] r = '0;
      for (int b = 0; b < NB; b++) if (b < n) r[8*b +: 8] = d[8*b +: 8];
      return r;
   endfunction

   int st_cyc = 0;
   task automatic run(input logic [3:0] c, input logic [19:0] a, input int n, input logic [DW-1:0] wd);
      n_rst = 0; n_att = 0; n_done = 0; own_seen = 1'b0; t_rst = 0;
      cmd_type = c; addr = a; byte_count = 5'(n); wdata = wd;
      st_cyc = cyc;
      start = 1'b1; step(); start = 1'b0;
      for (int g = 0; g < 80000 && n_done == 0; g++) step();
      step(); step();
      chk(own_at_done == 1'b0, "R9 own released at done", 128'(own_at_done), 0);
      chk(busy == 1'b0 && n_done == 1, "R11 single done, idle after", 128'(n_done), 1);
   endtask

   logic [DW-1:0] rd_prev;
   bit fin_flag = 0;

   initial begin
      #(200000 * 10);
      if (!fin_flag) begin
         n_bad++; n_cmp++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) step();
      // R12 reset state
      chk(busy == 0 && done == 0 && own_req == 0 && chan_rst == 0 && xfer_req == 0,
          "R12 outputs idle in reset", 128'({busy, done, own_req, chan_rst, xfer_req}), 0);
      chk(rdata == '0, "R12 rdata zero", rdata, 0);
      rst_n = 1'b1; step();

      // R1 directed write, 5 bytes
      fail_n = 0;
      run(4'h8, 20'h00100, 5, {16{8'hA5}} ^ 128'h0f0e0d0c0b0a09080706050403020100);
      chk(res_seen == 2'd0, "R6 write ok", 128'(res_seen), 0);
      chk(f_cmd == 4'h8 && f_len == 4'd4 && f_addr == 20'h00100, "R1 control fields",
          128'({f_cmd, f_len, f_addr}), 128'({4'h8, 4'd4, 20'h00100}));
      chk(f_wr == 128'h000000000000000000000000a1a6a7a4a5 >> 0 ? f_wr == f_mask(wdata, 5) : 1'b0,
          "R1 write packing", f_wr, f_mask(wdata, 5));
      chk(first_gap == 1 && n_rst == 1, "R5 first attempt immediate", 128'(first_gap), 1);

      // R8 directed read of 16 bytes
      rd_words = 128'hffeeddccbbaa99887766554433221100;
      run(4'h9, 20'h00200, 16, '1);
      chk(res_seen == 2'd0 && rdata == rd_words, "R8 full read", rdata, rd_words);
      chk(f_wr == '0, "R1 read sends zero payload", f_wr, 0);

      // R6 retries then success, R5 backoff spacing
      fail_n = 3;
      run(4'h8, 20'h00300, 2, 128'h1234);
      chk(res_seen == 2'd0 && n_att == 4, "R6 retries until ok", 128'(n_att), 4);
      chk(n_rst == 4, "R5 reset per attempt", 128'(n_rst), 4);
      chk(gap_min >= (BOFF - 1) * C && gap_max <= BOFF * C + 3, "R5 backoff gap",
          128'(gap_min), 128'(BOFF * C));

      // R8 failed read keeps rdata, R6 exhaustion
      rd_prev = rdata;
      rd_words = 128'h55;
      fail_n = 100;
      run(4'h9, 20'h00400, 4, '0);
      chk(res_seen == 2'd3 && n_att == MAXT, "R6 exhaust attempts", 128'(n_att), MAXT);
      chk(rdata == rd_prev, "R8 failed read keeps rdata", rdata, rd_prev);
      fail_n = 0;

      // R7 reply never arrives
      hang = 1;
      run(4'h9, 20'h00500, 1, '0);
      chk(res_seen == 2'd3 && n_att == 1, "R7 timeout no retry", 128'(n_att), 1);
      chk(t_done - t_req >= (TDN - 1) * C && t_done - t_req <= TDN * C + 4, "R7 timeout span",
          128'(t_done - t_req), 128'(TDN * C));
      hang = 0;

      // R4 no sink
      sink_present = 1'b0;
      run(4'h8, 20'h00600, 3, '1);
      chk(res_seen == 2'd2 && n_att == 0, "R4 no device, no request", 128'(n_att), 0);
      sink_present = 1'b1;

      // R3 grant never comes
      grant_en = 0;
      run(4'h8, 20'h00700, 3, '1);
      chk(res_seen == 2'd1 && n_att == 0, "R3 grant timeout busy", 128'(res_seen), 1);
      grant_en = 1;

      // R2 channel stays busy; R10 second start while busy
      chan_busy = 1'b1;
      fork
         run(4'h8, 20'h00800, 3, '1);
         begin
            repeat (50) step();
            start = 1'b1; cmd_type = 4'h9; step(); start = 1'b0;
         end
      join
      chk(res_seen == 2'd1 && own_seen == 1'b0, "R2 busy timeout, no ownership",
          128'({res_seen, own_seen}), 128'({2'd1, 1'b0}));
      chk(t_done - st_cyc >= (TIDL - 1) * C && t_done - st_cyc <= TIDL * C + 6, "R2 idle wait span",
          128'(t_done - st_cyc), 128'(TIDL * C));
      chan_busy = 1'b0;
      repeat (20) step();
      chk(n_done == 1 && busy == 1'b0, "R10 start while busy ignored", 128'(n_done), 1);

      // Random mix
      for (int i = 0; i < 20; i++) begin
         logic [3:0] c;
         logic [19:0] a;
         int n;
         logic [DW-1:0] wd;
         c = 4'($urandom_range(0, 15));
         a = 20'($urandom);
         n = $urandom_range(1, NB);
         wd = {$urandom, $urandom, $urandom, $urandom};
         rd_words = {$urandom, $urandom, $urandom, $urandom};
         fail_n = $urandom_range(0, 2);
         done_dly = $urandom_range(0, 20);
         rd_prev = rdata;
         run(c, a, n, wd);
         chk(res_seen == 2'd0 && n_att == fail_n + 1, "R6 random ok", 128'(n_att), 128'(fail_n + 1));
         chk(f_cmd == c && f_len == 4'(n - 1) && f_addr == a, "R1 random fields",
             128'({f_cmd, f_len, f_addr}), 128'({c, 4'(n - 1), a}));
         if (c[0]) begin
            chk(rdata == f_mask(rd_words, n), "R8 random read", rdata, f_mask(rd_words, n));
            chk(f_wr == '0, "R1 random read payload zero", f_wr, 0);
         end else begin
            chk(f_wr == f_mask(wd, n), "R1 random write packing", f_wr, f_mask(wd, n));
            chk(rdata == rd_prev, "R8 write leaves rdata", rdata, rd_prev);
         end
      end

      fin_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule